// File: doc/BRIEF.md
# Octal DDR Flash Read Prefetch Controller

This block drives the transmit side of memory-mapped reads from an octal double-data-rate flash. It keeps one pointer to the address the next bus read is expected to ask for. Each bus strobe compares its address with that pointer. On a match the data is already in flight into the receive FIFO, so the block only advances the pointer and leaves the flash running. On a mismatch it takes the new address and resets the FIFO with a fixed-length clocked reset. It then opens chip select, sends the read command and the address as 16-bit words, and counts a programmable number of dummy cycles. After that it keeps the flash clock running so the FIFO fills up ahead of the bus.

Each 16-bit output word leaves the block in one system cycle. Downstream pin logic sends it as two octal DDR beats. During prefill the clock gate simply follows the FIFO full flag. When the FIFO drains below full, the gate reopens under the same chip select, with no new command. Only an address mismatch ends the run.

Top module: `oflash_prefetch`

## Requirements
- R1: While reset is held, and right after it, `cs_n` is 1 and `sclk_en`, `tx_oe`, `fifo_rst`, `fifo_rst_clk`, `hit` and `miss` are all 0.
- R2: The first strobe after reset is always a miss, whatever its address.
- R3: A miss shows `miss` high for one cycle, starting the cycle after the strobe. From that same cycle, `fifo_rst` and `fifo_rst_clk` stay high for exactly RST_CYCLES (default 5) cycles, and `cs_n` stays 1 throughout.
- R4: In the cycle after the FIFO reset, `cs_n` is 0, `tx_oe` is 1 and `tx_data` is the command word {OPC, ~OPC}, which is 16'hEE11 by default.
- R5: The next two cycles carry the address latched at the miss: bits 31:16 first, then bits 15:0, with `tx_oe` high.
- R6: After the address, `sclk_en` stays 1 with `tx_oe` 0 for exactly `dummy_cycles` cycles. A value of 0 goes straight to prefill.
- R7: In prefill, `cs_n` stays 0 and `sclk_en` equals the inverse of `fifo_full`. When full drops, the clock resumes with no new command word.
- R8: A strobe whose address equals the pointer gives `hit` for one cycle, starting the cycle after the strobe, and the pointer advances by STEP (4) bytes. The flash sequence is not disturbed: no FIFO reset and no command.
- R9: A mismatching strobe during the dummy or prefill phase aborts the run and restarts the R3–R5 sequence with the new address.
- R10: After a miss at address A, the pointer holds A+STEP, so a strobe at A+STEP hits. A repeat strobe at A misses. The pointer wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus read strobe, one cycle per request |
| bus_addr | input | 32 | Byte address of the bus read |
| dummy_cycles | input | 5 | Programmable dummy cycle count |
| fifo_full | input | 1 | Receive FIFO full flag |
| hit | output | 1 | Strobe matched the next-read pointer |
| miss | output | 1 | Strobe did not match; a new read starts |
| fifo_rst | output | 1 | Receive FIFO reset |
| fifo_rst_clk | output | 1 | Request to cycle both FIFO clocks during reset |
| cs_n | output | 1 | Flash chip select, active low |
| sclk_en | output | 1 | Flash clock gate enable |
| tx_oe | output | 1 | Output data enable for command and address |
| tx_data | output | 16 | Word sent as two octal DDR beats |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 5-bit dummy count, a 5-cycle FIFO reset and opcode 8'hEE. With those values, every phase of a miss sequence can be counted cycle by cycle. The runtime dummy count is driven to 0, 3 and 20. The value 0 reaches the skip path. The value 20 gives a long window for an abort. Holding the FIFO full during the dummy phase marks the exact cycle where the dummy phase ends and the full-gated prefill begins. An address table walks hits, repeated misses, jumps back to older lines and a pointer wrap at the top of the 32-bit space.

// File: rtl/oflash_prefetch.sv
module oflash_prefetch #(
  parameter int        AW         = 32,
  parameter int        DW         = 5,
  parameter int        RST_CYCLES = 5,
  parameter int        STEP       = 4,
  parameter logic[7:0] OPC        = 8'hEE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] dummy_cycles,
  input  logic          fifo_full,
  output logic          hit,
  output logic          miss,
  output logic          fifo_rst,
  output logic          fifo_rst_clk,
  output logic          cs_n,
  output logic          sclk_en,
  output logic          tx_oe,
  output logic [15:0]   tx_data
);
  localparam int RCW = $clog2(RST_CYCLES + 1);
  localparam logic [15:0] CMD_WORD = {OPC, ~OPC};

  typedef enum logic [2:0] {S_IDLE, S_FRST, S_CMD, S_ADRH, S_ADRL, S_DUMMY, S_FILL} st_t;

  st_t           state;
  logic [AW-1:0] ptr, cmd_addr;
  logic          ptr_vld;
  logic [RCW-1:0] rcnt;
  logic [DW-1:0] dcnt;
  logic [31:0]   a32;

  wire match   = ptr_vld && (bus_addr == ptr);
  wire restart = bus_req && !match;

  assign a32 = 32'(cmd_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ptr      <= '0;
      ptr_vld  <= 1'b0;
      cmd_addr <= '0;
      rcnt     <= '0;
      dcnt     <= '0;
      hit      <= 1'b0;
      miss     <= 1'b0;
    end else begin
      hit  <= bus_req && match;
      miss <= restart;
      if (bus_req && match) ptr <= ptr + AW'(STEP);
      if (restart) begin
        ptr      <= bus_addr + AW'(STEP);
        cmd_addr <= bus_addr;
        ptr_vld  <= 1'b1;
        rcnt     <= RCW'(RST_CYCLES - 1);
        state    <= S_FRST;
      end else begin
        case (state)
          S_FRST:  if (rcnt == '0) state <= S_CMD;
                   else rcnt <= rcnt - 1'b1;
          S_CMD:   state <= S_ADRH;
          S_ADRH:  state <= S_ADRL;
          S_ADRL:  if (dummy_cycles == '0) state <= S_FILL;
                   else begin
                     dcnt  <= dummy_cycles - 1'b1;
                     state <= S_DUMMY;
                   end
          S_DUMMY: if (dcnt == '0) state <= S_FILL;
                   else dcnt <= dcnt - 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign cs_n         = (state == S_IDLE) || (state == S_FRST);
  assign fifo_rst     = (state == S_FRST);
  assign fifo_rst_clk = (state == S_FRST);
  assign tx_oe        = (state == S_CMD) || (state == S_ADRH) || (state == S_ADRL);
  assign sclk_en      = tx_oe || (state == S_DUMMY) || ((state == S_FILL) && !fifo_full);

  always_comb begin
    case (state)
      S_CMD:   tx_data = CMD_WORD;
      S_ADRH:  tx_data = a32[31:16];
      S_ADRL:  tx_data = a32[15:0];
      default: tx_data = '0;
    endcase
  end

  AST_MISS_RESETS: assert property (@(posedge clk) disable iff (!rst_n) miss |-> fifo_rst); // R3
  AST_RST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) fifo_rst |-> cs_n); // R3
  AST_CMD_FOLLOWS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_rst) |-> (tx_oe && tx_data == CMD_WORD)); // R4
  AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADRL) |-> ($past(state) == S_ADRH)); // R5
  AST_CLK_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) sclk_en |-> !cs_n); // R7
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(hit && miss)); // R8
endmodule

// File: tb/oflash_prefetch_tb.sv
`timescale 1ns/1ps
module oflash_prefetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [4:0]  dummy_cycles = 5'd3;
  logic        fifo_full = 1'b0;
  logic        hit, miss, fifo_rst, fifo_rst_clk, cs_n, sclk_en, tx_oe;
  logic [15:0] tx_data;

  int errors = 0;
  int checks = 0;

  oflash_prefetch u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
    .dummy_cycles(dummy_cycles), .fifo_full(fifo_full), .hit(hit), .miss(miss),
    .fifo_rst(fifo_rst), .fifo_rst_clk(fifo_rst_clk), .cs_n(cs_n),
    .sclk_en(sclk_en), .tx_oe(tx_oe), .tx_data(tx_data)
  );

  always #2.5 clk = ~clk;

  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {32'h0000_1000, 1'b0}, {32'h0000_1004, 1'b1}, {32'h0000_1008, 1'b1},
    {32'h0000_2000, 1'b0}, {32'h0000_2004, 1'b1}, {32'h0000_2008, 1'b1},
    {32'h0000_1000, 1'b0}, {32'h0000_1004, 1'b1}, {32'h0000_1004, 1'b0},
    {32'h0000_1008, 1'b1}, {32'hFFFF_FFFC, 1'b0}, {32'h0000_0000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [31:0] a);
    @(negedge clk); bus_req = 1'b1; bus_addr = a;
    @(negedge clk); bus_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_rst_phase(input string req);
    for (int i = 0; i < 5; i++) begin
      chk(req, {29'd0, fifo_rst, fifo_rst_clk, cs_n}, 32'd7);
      @(negedge clk);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state, during and right after reset
    chk("R1", {26'd0, cs_n, sclk_en, tx_oe, fifo_rst, hit, miss}, 32'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {25'd0, cs_n, sclk_en, tx_oe, fifo_rst, fifo_rst_clk, hit, miss}, 32'b1000000);

    // R2 first strobe misses; R8 R10 table walk of hits and misses
    for (int v = 0; v < NV; v++) begin
      strobe(VEC[v][32:1]);
      chk(v == 0 ? "R2" : (VEC[v][0] ? "R8" : "R10"), {30'd0, hit, miss},
          VEC[v][0] ? 32'd2 : 32'd1);
      idle(12);
    end

    // R3 R4 R5 R6 full miss sequence with 3 dummy cycles
    dummy_cycles = 5'd3;
    fifo_full = 1'b1;
    strobe(32'hABCD_1234);
    chk("R3", {31'd0, miss}, 32'd1);
    check_rst_phase("R3");
    chk("R4", {14'd0, cs_n, tx_oe, tx_data}, {14'd0, 1'b0, 1'b1, 16'hEE11});
    @(negedge clk);
    chk("R5", {15'd0, tx_oe, tx_data}, {15'd0, 1'b1, 16'hABCD});
    @(negedge clk);
    chk("R5", {15'd0, tx_oe, tx_data}, {15'd0, 1'b1, 16'h1234});
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R6", {29'd0, cs_n, sclk_en, tx_oe}, 32'b010);
      @(negedge clk);
    end
    // R7 prefill gated by full
    chk("R7", {30'd0, cs_n, sclk_en}, 32'b00);
    fifo_full = 1'b0;
    #0.1;
    chk("R7", {29'd0, cs_n, sclk_en, tx_oe}, 32'b010);
    idle(4);
    fifo_full = 1'b1;
    #0.1;
    chk("R7", {30'd0, cs_n, sclk_en}, 32'b00);
    fifo_full = 1'b0;
    idle(2);
    chk("R7", {29'd0, cs_n, sclk_en, tx_oe}, 32'b010);

    // R8 sequential hit leaves flash run untouched
    strobe(32'hABCD_1238);
    chk("R8", {27'd0, hit, fifo_rst, cs_n, tx_oe, sclk_en}, 32'b10001);
    idle(6);
    chk("R8", {28'd0, fifo_rst, cs_n, tx_oe, sclk_en}, 32'b0001);

    // R9 abort during long dummy phase
    dummy_cycles = 5'd20;
    strobe(32'h0000_0500);
    idle(5 + 3 + 4);
    chk("R9", {29'd0, cs_n, sclk_en, tx_oe}, 32'b010);
    strobe(32'h0000_0900);
    chk("R9", {30'd0, miss, fifo_rst}, 32'b11);
    check_rst_phase("R9");
    chk("R9", {16'd0, tx_data}, 32'h0000_EE11);
    @(negedge clk);
    chk("R9", {16'd0, tx_data}, 32'h0000_0000);
    @(negedge clk);
    chk("R9", {16'd0, tx_data}, 32'h0000_0900);

    // R6 zero dummy count goes straight to prefill
    dummy_cycles = 5'd0;
    fifo_full = 1'b1;
    strobe(32'h0000_0040);
    idle(5 + 3);
    chk("R6", {29'd0, cs_n, sclk_en, tx_oe}, 32'b000);
    fifo_full = 1'b0;
    #0.1;
    chk("R6", {30'd0, cs_n, sclk_en}, 32'b01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule